// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Link Codec

This block carries binary words across a two-wire-per-bit link with no spacer phase between words. The transmitter half holds one data wire and one phase wire for every bit. Each time it is told to send, it moves every bit pair to the next token by changing exactly one wire of the pair. The data wire changes when the bit's value changes. Otherwise the phase wire changes. The token parity of a bit (data XOR phase) therefore alternates with every word, whatever the word's value.

The receiver half samples the wire pairs on each clock and compares every bit's token parity with the parity it expects next. When all bits match, the new word has fully arrived. The receiver then latches the data wires as the decoded word, pulses a completion strobe for one cycle, and inverts its expectation. If both wires of any bit change between two samples, the receiver raises a sticky error flag, since that is not a legal transition. The line wires are brought out of the transmitter and the receiver takes its own inputs. A system can join them directly or route them through any path that keeps each pair coherent per sample.

Top module: `ledr_codec`

## Requirements
- R1: After reset, every line data and line phase wire is 0, rx_done is 0, rx_err is 0, rx_word is 0, and the receiver expects token parity 1 for the first word.
- R2: A word presented with tx_send high at a rising edge appears on line_data after that edge. Every bit whose value differs from the previous word keeps its line_phase wire unchanged.
- R3: Every bit whose value equals the previous word keeps its line_data wire and inverts its line_phase wire.
- R4: While tx_send is low, line_data and line_phase do not change.
- R5: On every send, each bit changes exactly one of its two wires, so every bit's parity (data XOR phase) inverts.
- R6: The receiver registers its inputs at each edge. When every sampled bit's parity equals the expected parity, rx_done is 1 for the following cycle, rx_word shows the sampled data wires, and the expected parity inverts. With the line looped back, rx_done is high during the cycle that begins two edges after the sending edge. rx_word changes only when rx_done rises.
- R7: While at least one bit still shows the old parity, rx_done stays 0 and rx_word holds.
- R8: If both wires of any bit differ between one sample and the next, rx_err becomes 1 after that edge and stays 1 until reset.
- R9: Sends on consecutive cycles each produce a one-cycle rx_done on consecutive cycles, and each carries its own word in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_send | input | 1 | Send strobe: take tx_word as the next token |
| tx_word | input | WIDTH | Word to transmit |
| line_data | output | WIDTH | Transmit data wire of each bit |
| line_phase | output | WIDTH | Transmit phase wire of each bit |
| rx_data | input | WIDTH | Receive data wire of each bit |
| rx_phase | input | WIDTH | Receive phase wire of each bit |
| rx_word | output | WIDTH | Last decoded word |
| rx_done | output | 1 | One-cycle completion strobe for a decoded word |
| rx_err | output | 1 | Sticky flag: both wires of a bit changed in one sample |

## Verification
The bench builds the codec with WIDTH = 8. With that width a single word can mix bits that change value with bits that hold, so the data-wire and phase-wire paths are both exercised in the same token. Eight bits also leave room to hold back part of a word on a hand-driven receive side, which makes incomplete arrival and single-bit double transitions observable. In loopback the same width carries alternating, all-equal and all-flipped words, back to back.

// File: rtl/ledr_pkg.sv
// Package: shared types for the level-encoded dual-rail codec.
// Assumes: nothing beyond standard SystemVerilog packed structs.
package ledr_pkg;

    // One bit's wire pair: value wire and alternating phase wire.
    typedef struct packed {
        logic d;
        logic p;
    } ledr_pair_t;

    // Token parity of one wire pair.
    function automatic logic pair_parity(input ledr_pair_t pr);
        return pr.d ^ pr.p;
    endfunction

endpackage

// File: rtl/ledr_tx_lane.sv
// Module: ledr_tx_lane
// Drives one bit's data/phase pair. On load it moves to the next token by
// changing exactly one wire: data when the bit value changes, phase otherwise.
// Assumes: load is a clean synchronous strobe.
module ledr_tx_lane
    import ledr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       bit_i,
    output ledr_pair_t pair_o
);

    ledr_pair_t pair_q;

    // Wire-pair register: advance one token per load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else if (load) begin
            pair_q.d <= bit_i;
            if (bit_i == pair_q.d) begin
                pair_q.p <= ~pair_q.p;
            end
        end
    end

    assign pair_o = pair_q;

endmodule

// File: rtl/ledr_encoder.sv
// Module: ledr_encoder
// Transmit side: one lane per bit, all lanes updated in the same cycle.
// Assumes: WIDTH >= 1.
module ledr_encoder
    import ledr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] data_o,
    output logic [WIDTH-1:0] phase_o
);

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_lane
        ledr_pair_t pr;

        ledr_tx_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (send),
            .bit_i  (word[gi]),
            .pair_o (pr)
        );

        assign data_o[gi]  = pr.d;
        assign phase_o[gi] = pr.p;
    end

endmodule

// File: rtl/ledr_rx_lane.sv
// Module: ledr_rx_lane
// Samples one bit's wire pair each cycle, reports its token parity and data,
// and flags an illegal sample where both wires differ from the last sample.
// Assumes: inputs are already synchronous to clk.
module ledr_rx_lane
    import ledr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    input  logic p_i,
    output logic parity_o,
    output logic data_o,
    output logic clash_o
);

    ledr_pair_t smp_q;

    // Sample register: holds the pair seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q.d <= d_i;
            smp_q.p <= p_i;
        end
    end

    assign parity_o = pair_parity(smp_q);
    assign data_o   = smp_q.d;
    // Both wires moving between two samples is not a legal token step.
    assign clash_o  = (d_i ^ smp_q.d) & (p_i ^ smp_q.p);

endmodule

// File: rtl/ledr_decoder.sv
// Module: ledr_decoder
// Receive side: completion detection over all lanes, decoded word latch,
// one-cycle done strobe, expected-parity toggle and sticky clash flag.
// Assumes: each pair changes coherently per sample.
module ledr_decoder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] phase_i,
    output logic [WIDTH-1:0] word_o,
    output logic             done_o,
    output logic             err_o
);

    logic [WIDTH-1:0] par;
    logic [WIDTH-1:0] smp_data;
    logic [WIDTH-1:0] clash;
    logic             expect_q;
    logic             complete;
    logic [WIDTH-1:0] word_q;
    logic             done_q;
    logic             err_q;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_lane
        ledr_rx_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .d_i      (data_i[gi]),
            .p_i      (phase_i[gi]),
            .parity_o (par[gi]),
            .data_o   (smp_data[gi]),
            .clash_o  (clash[gi])
        );
    end

    // Completion: every lane has reached the expected token parity.
    assign complete = (par == {WIDTH{expect_q}});

    // Token acceptance: latch word, strobe done, flip expected parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_q <= 1'b1;
            word_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= complete;
            if (complete) begin
                word_q   <= smp_data;
                expect_q <= ~expect_q;
            end
        end
    end

    // Sticky error: any lane with a double-wire change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (|clash) begin
            err_q <= 1'b1;
        end
    end

    assign word_o = word_q;
    assign done_o = done_q;
    assign err_o  = err_q;

endmodule

// File: rtl/ledr_codec.sv
// Module: ledr_codec (top)
// Transmitter and receiver for a level-encoded dual-rail word link.
// Line outputs and receive inputs are separate ports so the link path is
// chosen by the surrounding logic.
// Assumes: synchronous active-low reset held for at least one edge.
module ledr_codec #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_send,
    input  logic [WIDTH-1:0] tx_word,
    output logic [WIDTH-1:0] line_data,
    output logic [WIDTH-1:0] line_phase,
    input  logic [WIDTH-1:0] rx_data,
    input  logic [WIDTH-1:0] rx_phase,
    output logic [WIDTH-1:0] rx_word,
    output logic             rx_done,
    output logic             rx_err
);

    ledr_encoder #(.WIDTH(WIDTH)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .send    (tx_send),
        .word    (tx_word),
        .data_o  (line_data),
        .phase_o (line_phase)
    );

    ledr_decoder #(.WIDTH(WIDTH)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (rx_data),
        .phase_i (rx_phase),
        .word_o  (rx_word),
        .done_o  (rx_done),
        .err_o   (rx_err)
    );

endmodule

// File: rtl/ledr_codec_chk.sv
// Module: ledr_codec_chk
// Property checker for ledr_codec, attached by bind.
// Assumes: same WIDTH as the bound instance.
module ledr_codec_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_send,
    input logic [WIDTH-1:0] tx_word,
    input logic [WIDTH-1:0] line_data,
    input logic [WIDTH-1:0] line_phase,
    input logic [WIDTH-1:0] rx_word,
    input logic             rx_done,
    input logic             rx_err
);

    AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |=> (line_data == $past(tx_word))); // R2

    AST_EQUAL_FLIPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |=> ((line_phase ^ $past(line_phase)) == ~($past(tx_word) ^ $past(line_data)))); // R3

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_send |=> ($stable(line_data) && $stable(line_phase))); // R4

    AST_ONE_WIRE_PER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_send |=> (((line_data ^ $past(line_data)) ^ (line_phase ^ $past(line_phase))) == '1)); // R5

    AST_WORD_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable(rx_word)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> rx_err); // R8

endmodule

bind ledr_codec ledr_codec_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_send    (tx_send),
    .tx_word    (tx_word),
    .line_data  (line_data),
    .line_phase (line_phase),
    .rx_word    (rx_word),
    .rx_done    (rx_done),
    .rx_err     (rx_err)
);

// File: tb/test_ledr_codec.sv
// Directed bench for ledr_codec: loopback and hand-driven receive scenarios.
module test_ledr_codec;

    localparam int WIDTH  = 8;
    localparam int PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             tx_send;
    logic [WIDTH-1:0] tx_word;
    logic [WIDTH-1:0] line_data;
    logic [WIDTH-1:0] line_phase;
    logic [WIDTH-1:0] rx_data;
    logic [WIDTH-1:0] rx_phase;
    logic [WIDTH-1:0] rx_word;
    logic             rx_done;
    logic             rx_err;

    logic             manual;
    logic [WIDTH-1:0] m_data;
    logic [WIDTH-1:0] m_phase;

    int vectors   = 0;
    int miscomp   = 0;

    // Bench-side model of the line.
    logic [WIDTH-1:0] mdl_d;
    logic [WIDTH-1:0] mdl_p;

    always #(PERIOD/2) clk = ~clk;

    assign rx_data  = manual ? m_data  : line_data;
    assign rx_phase = manual ? m_phase : line_phase;

    ledr_codec #(.WIDTH(WIDTH)) i_ledr_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_send    (tx_send),
        .tx_word    (tx_word),
        .line_data  (line_data),
        .line_phase (line_phase),
        .rx_data    (rx_data),
        .rx_phase   (rx_phase),
        .rx_word    (rx_word),
        .rx_done    (rx_done),
        .rx_err     (rx_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        tx_send = 1'b0;
        tx_word = '0;
        m_data  = '0;
        m_phase = '0;
        mdl_d   = '0;
        mdl_p   = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset values of all outputs.
    task automatic t_reset();
        manual = 1'b0;
        do_reset();
        check("R1 line_data",  32'(line_data),  0);
        check("R1 line_phase", 32'(line_phase), 0);
        check("R1 rx_done",    32'(rx_done),    0);
        check("R1 rx_err",     32'(rx_err),     0);
        check("R1 rx_word",    32'(rx_word),    0);
    endtask

    // R2/R3/R6: one word in loopback, line and decode timing.
    task automatic send_one(input logic [WIDTH-1:0] w);
        logic [WIDTH-1:0] nd;
        logic [WIDTH-1:0] np;
        nd = w;
        np = mdl_p ^ ~(mdl_d ^ w);
        tx_send = 1'b1;
        tx_word = w;
        @(negedge clk);
        tx_send = 1'b0;
        check("R2 line_data",  32'(line_data),  32'(nd));
        check("R3 line_phase", 32'(line_phase), 32'(np));
        check("R5 parity flip", 32'((line_data ^ line_phase) ^ (mdl_d ^ mdl_p)), 32'({WIDTH{1'b1}}));
        mdl_d = nd;
        mdl_p = np;
        @(negedge clk);
        check("R6 done not early", 32'(rx_done), 0);
        @(negedge clk);
        check("R6 done", 32'(rx_done), 1);
        check("R6 word", 32'(rx_word), 32'(w));
        @(negedge clk);
        check("R6 done one cycle", 32'(rx_done), 0);
        check("R6 word held", 32'(rx_word), 32'(w));
    endtask

    task automatic t_loopback();
        manual = 1'b0;
        do_reset();
        send_one(8'hA5);
        send_one(8'hA5);
        send_one(8'h5A);
        send_one(8'h00);
        send_one(8'hF0);
        check("R8 no err in loopback", 32'(rx_err), 0);
    endtask

    // R4: line is stable without send.
    task automatic t_hold();
        logic [WIDTH-1:0] d0;
        logic [WIDTH-1:0] p0;
        d0 = line_data;
        p0 = line_phase;
        tx_word = 8'h3C;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R4 data hold",  32'(line_data),  32'(d0));
            check("R4 phase hold", 32'(line_phase), 32'(p0));
            check("R4 no done",    32'(rx_done),    0);
        end
    endtask

    // R9: back-to-back sends.
    task automatic t_burst();
        logic [WIDTH-1:0] ws [3];
        ws[0] = 8'h11;
        ws[1] = 8'h11;
        ws[2] = 8'hEE;
        manual = 1'b0;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            tx_send = 1'b1;
            tx_word = ws[i];
            @(negedge clk);
        end
        tx_send = 1'b0;
        // first done appears at the third negedge after driving word 0
        for (int i = 0; i < 3; i++) begin
            check("R9 done burst", 32'(rx_done), 1);
            check("R9 word order", 32'(rx_word), 32'(ws[i]));
            @(negedge clk);
        end
        check("R9 done ends", 32'(rx_done), 0);
    endtask

    // R7: partial arrival does not complete.
    task automatic t_partial();
        manual = 1'b1;
        do_reset();
        m_data = 8'h01;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 no done partial", 32'(rx_done), 0);
            check("R7 word held",       32'(rx_word), 0);
        end
        m_phase = 8'hFE;
        @(negedge clk);
        check("R7 not yet", 32'(rx_done), 0);
        @(negedge clk);
        check("R7 done when all", 32'(rx_done), 1);
        check("R7 word",          32'(rx_word), 32'h01);
        check("R8 no err",        32'(rx_err),  0);
    endtask

    // R8: double-wire change sets a sticky error.
    task automatic t_error();
        manual = 1'b1;
        do_reset();
        m_data  = 8'h08;
        m_phase = 8'h08;
        @(negedge clk);
        check("R8 err set", 32'(rx_err), 1);
        m_data  = 8'h00;
        m_phase = 8'h08;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 err sticky", 32'(rx_err), 1);
        end
        do_reset();
        check("R8 err cleared by reset", 32'(rx_err), 0);
    endtask

    initial begin
        rst_n   = 1'b0;
        tx_send = 1'b0;
        tx_word = '0;
        manual  = 1'b0;
        m_data  = '0;
        m_phase = '0;
        t_reset();
        t_loopback();
        t_hold();
        t_burst();
        t_partial();
        t_error();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(PERIOD * 100000);
        miscomp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule